// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a synchronous host and an asynchronous x4 dynamic RAM that supports fast page mode. The host offers one access at a time through a valid/ready pair: a write flag, a 22-bit word address and 4 bits of write data. Reads return 4 bits of data with a one-cycle valid pulse. On the memory side the block drives the row strobe, column strobe, write enable and output enable, all active low. It also drives an 11-bit multiplexed address bus and shares a 4-bit bidirectional data bus with the memory.

Each address is split into a row half and a column half, which share the same pins one after the other. After an access the row stays open. Further requests to the same row are served by column-strobe cycles only. A request to another row closes the open row, waits out the precharge time and opens the new row. The row is also closed when it has been open long enough to approach the page-mode limit on row strobe width. Every timing limit is a parameter given in clock cycles. A refresh-grant input from a separate refresh block makes the controller close any open row and stay idle until the grant is removed.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: The row half of a request is address bits [21:11] and the column half is bits [10:0]. The row half is on the address pins when the row strobe falls, and the column half is on them when the column strobe falls.
- R2: Once the row strobe falls, it stays low for at least T_RAS cycles (default 5).
- R3: Once the row strobe rises, it stays high for at least T_RP cycles (default 3) before it falls again.
- R4: The column strobe is low only while the row strobe is low. It falls no sooner than T_RCD cycles (default 2) after the row strobe falls.
- R5: Back-to-back requests to the open row cause no new row strobe fall. Between page accesses the column strobe stays high for at least T_CP cycles, and successive column strobe falls are at least T_PC cycles apart.
- R6: A write is an early write. Write enable is low, output enable is high and the write data is driven before the column strobe falls, so the memory stores that data.
- R7: A read holds write enable high and output enable low. Data is sampled after the column strobe has been low for max(T_CAS, T_CAC, T_AA-1) cycles and returned with a one-cycle rd_valid pulse as the column strobe rises.
- R8: A request to a row other than the open one closes that row, waits out precharge and opens the new row with a new row strobe fall.
- R9: The row strobe never stays low longer than T_RASP cycles. The row is closed and reopened when this limit would be exceeded.
- R10: While ref_grant is high, req_ready is low, any open row is closed, and the row strobe does not fall.
- R11: During and right after reset, all four strobes are high, rd_valid is low and the controller is ready for a request.
- R12: Reads complete in the order they were accepted, with exactly one rd_valid pulse per read and none for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address, row in [21:11], column in [10:0] |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 4 | Read data |
| ref_grant | input | 1 | Refresh owns the memory; close row and stay idle |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_dq | inout | 4 | Bidirectional data |

## Verification
Directed runs of same-row bursts separate page hits (one row strobe fall for many accesses) from row misses (a fall per row change). A pair of rows that share column values shows whether the row half and the column half reach the right pins. A long unbroken same-row stream checks that the row is forcibly closed under the page-width limit. Constrained-random traffic over a few rows mixes reads and writes with random gaps and checks every returned word against a shadow copy. A bench memory model drives invalid data until the column strobe has been low long enough, so a read sampled too early returns the wrong value.

// File: rtl/fpm_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the fast page mode controller.
package fpm_pkg;

    // Sequencer states: row closed, waiting before first column, column
    // strobe low, row open and idle, column precharge, waiting to close.
    typedef enum logic [2:0] {
        ST_CLOSED,
        ST_RCD,
        ST_CAS,
        ST_OPEN,
        ST_CP,
        ST_CLOSING
    } fpm_state_e;

    // Larger of two integers, for parameter arithmetic.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpm_cycle_timer.sv
`timescale 1ns/1ps
// Loadable down-counter. done is high when the count has reached zero.
// Assumes load_val fits in W bits.
module fpm_cycle_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    // Count down to zero, restart on load.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (load)      cnt <= load_val;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/fpm_row_track.sv
`timescale 1ns/1ps
// Remembers which row is open and how many cycles the row strobe has been
// low. Assumes open_row and close_row are never high in the same cycle.
module fpm_row_track #(
    parameter int ROW_W   = 11,
    parameter int AGE_W   = 16,
    parameter int AGE_LIM = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_row,
    input  logic             close_row,
    input  logic [ROW_W-1:0] new_row,
    input  logic [ROW_W-1:0] probe_row,
    output logic             row_hit,
    output logic [AGE_W-1:0] age,
    output logic             age_over
);
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    logic [ROW_W-1:0] cur_row;

    // Capture the row address when the row opens.
    always_ff @(posedge clk) begin
        if (!rst_n)        cur_row <= '0;
        else if (open_row) cur_row <= new_row;
    end

    // Count the cycles the row strobe has been low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                              age <= '0;
        else if (open_row)                       age <= AGE_W'(1);
        else if (close_row)                      age <= '0;
        else if (age != '0 && age != AGE_MAX)    age <= age + 1'b1;
    end

    assign row_hit  = (probe_row == cur_row);
    assign age_over = (age >= AGE_W'(AGE_LIM));
endmodule

// File: rtl/fpm_dram_ctrl.sv
`timescale 1ns/1ps
// Fast page mode DRAM controller. It takes one host request at a time,
// keeps the row open for following same-row requests, and closes it on a
// row miss, on a refresh grant, or before the row-strobe width limit.
// Assumes T_RASP > T_RAS + the worst access span, and an early-write-only
// memory. Timing parameters are cycle counts.
module fpm_dram_ctrl import fpm_pkg::*; #(
    parameter int ROW_W  = 11,
    parameter int COL_W  = 11,
    parameter int DQ_W   = 4,
    parameter int T_RAS  = 5,
    parameter int T_RP   = 3,
    parameter int T_RCD  = 2,
    parameter int T_CAS  = 1,
    parameter int T_CP   = 1,
    parameter int T_PC   = 2,
    parameter int T_CAC  = 2,
    parameter int T_AA   = 3,
    parameter int T_RASP = 10000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [ROW_W+COL_W-1:0]   req_addr,
    input  logic [DQ_W-1:0]          req_wdata,
    output logic                     rd_valid,
    output logic [DQ_W-1:0]          rd_data,
    input  logic                     ref_grant,
    output logic                     dram_ras_n,
    output logic                     dram_cas_n,
    output logic                     dram_we_n,
    output logic                     dram_oe_n,
    output logic [imax(ROW_W,COL_W)-1:0] dram_addr,
    inout  wire  [DQ_W-1:0]          dram_dq
);
    localparam int ADDR_W   = ROW_W + COL_W;
    localparam int PIN_W    = imax(ROW_W, COL_W);
    localparam int RCD_EFF  = imax(T_RCD, 2);
    localparam int LOW_RD   = imax(imax(T_CAS, T_CAC), T_AA - 1);
    localparam int LOW_WR   = imax(T_CAS, 1);
    localparam int CP_EFF   = imax(T_CP, 1);
    localparam int PC_EFF   = imax(T_PC, 1);
    localparam int RP_EFF   = imax(T_RP, 1);
    localparam int STEP_W   = $clog2(imax(imax(RCD_EFF, LOW_RD), CP_EFF) + 1);
    localparam int PC_W     = $clog2(PC_EFF + 1);
    localparam int PRE_W    = $clog2(RP_EFF + 1);
    localparam int ACC_SPAN = CP_EFF + PC_EFF + LOW_RD + 3;
    localparam int AGE_LIM  = T_RASP - ACC_SPAN;
    localparam int AGE_W    = $clog2(T_RASP + 2) + 1;

    fpm_state_e         state;
    logic               cmd_wr;
    logic [COL_W-1:0]   cmd_col;
    logic               dq_oe;
    logic [DQ_W-1:0]    dq_out;

    logic [ROW_W-1:0]   req_row;
    logic [COL_W-1:0]   req_col;
    logic               accept, open_now, cas_fire, cas_end, ras_up;
    logic               row_hit, age_over;
    logic [AGE_W-1:0]   age;
    logic               step_load, step_done, pc_done, pre_done;
    logic [STEP_W-1:0]  step_val;

    assign req_row = req_addr[ADDR_W-1:COL_W];
    assign req_col = req_addr[COL_W-1:0];
    assign dram_dq = dq_oe ? dq_out : {DQ_W{1'bz}};

    // Spacing timer shared by row-to-column, column-low and column-high waits.
    fpm_cycle_timer #(.W(STEP_W)) step_tmr_i (
        .clk(clk), .rst_n(rst_n), .load(step_load),
        .load_val(step_val), .done(step_done)
    );

    // Minimum spacing between successive column strobe falls.
    fpm_cycle_timer #(.W(PC_W)) pc_tmr_i (
        .clk(clk), .rst_n(rst_n), .load(cas_fire),
        .load_val(PC_W'(PC_EFF - 1)), .done(pc_done)
    );

    // Row precharge between a row strobe rise and the next fall.
    fpm_cycle_timer #(.W(PRE_W)) pre_tmr_i (
        .clk(clk), .rst_n(rst_n), .load(ras_up),
        .load_val(PRE_W'(RP_EFF - 1)), .done(pre_done)
    );

    // Open-row address and row-strobe age.
    fpm_row_track #(.ROW_W(ROW_W), .AGE_W(AGE_W), .AGE_LIM(AGE_LIM)) row_i (
        .clk(clk), .rst_n(rst_n), .open_row(open_now), .close_row(ras_up),
        .new_row(req_row), .probe_row(req_row), .row_hit(row_hit),
        .age(age), .age_over(age_over)
    );

    // Decide acceptance, strobe events and timer loads for this cycle.
    always_comb begin
        req_ready = !ref_grant &&
                    ((state == ST_CLOSED && pre_done) ||
                     (state == ST_OPEN && row_hit && !age_over));
        accept    = req_valid && req_ready;
        open_now  = (state == ST_CLOSED) && accept;
        cas_fire  = (state == ST_RCD || state == ST_CP) && step_done && pc_done;
        cas_end   = (state == ST_CAS) && step_done;
        ras_up    = (state == ST_CLOSING) && (age >= AGE_W'(T_RAS));
        step_load = 1'b0;
        step_val  = '0;
        if (open_now) begin
            step_load = 1'b1;
            step_val  = STEP_W'(RCD_EFF - 1);
        end else if (cas_fire) begin
            step_load = 1'b1;
            step_val  = cmd_wr ? STEP_W'(LOW_WR - 1) : STEP_W'(LOW_RD - 1);
        end else if (cas_end) begin
            step_load = 1'b1;
            step_val  = STEP_W'(CP_EFF - 1);
        end
    end

    // Sequencer: drives strobes, address pins, data bus and read return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_CLOSED;
            cmd_wr     <= 1'b0;
            cmd_col    <= '0;
            dq_oe      <= 1'b0;
            dq_out     <= '0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            dram_ras_n <= 1'b1;
            dram_cas_n <= 1'b1;
            dram_we_n  <= 1'b1;
            dram_oe_n  <= 1'b1;
            dram_addr  <= '0;
        end else begin
            rd_valid <= 1'b0;
            case (state)
                ST_CLOSED: begin
                    if (accept) begin
                        dram_ras_n <= 1'b0;
                        dram_addr  <= PIN_W'(req_row);
                        cmd_wr     <= req_write;
                        cmd_col    <= req_col;
                        dram_we_n  <= !req_write;
                        dram_oe_n  <= req_write;
                        dq_oe      <= req_write;
                        dq_out     <= req_wdata;
                        state      <= ST_RCD;
                    end
                end
                ST_RCD, ST_CP: begin
                    dram_addr <= PIN_W'(cmd_col);
                    if (cas_fire) begin
                        dram_cas_n <= 1'b0;
                        state      <= ST_CAS;
                    end
                end
                ST_CAS: begin
                    if (cas_end) begin
                        dram_cas_n <= 1'b1;
                        dram_we_n  <= 1'b1;
                        dram_oe_n  <= 1'b1;
                        dq_oe      <= 1'b0;
                        if (!cmd_wr) begin
                            rd_data  <= dram_dq;
                            rd_valid <= 1'b1;
                        end
                        state <= ST_OPEN;
                    end
                end
                ST_OPEN: begin
                    if (accept) begin
                        dram_addr <= PIN_W'(req_col);
                        cmd_wr    <= req_write;
                        cmd_col   <= req_col;
                        dram_we_n <= !req_write;
                        dram_oe_n <= req_write;
                        dq_oe     <= req_write;
                        dq_out    <= req_wdata;
                        state     <= ST_CP;
                    end else if (ref_grant || age_over || (req_valid && !row_hit)) begin
                        state <= ST_CLOSING;
                    end
                end
                ST_CLOSING: begin
                    if (ras_up) begin
                        dram_ras_n <= 1'b1;
                        state      <= ST_CLOSED;
                    end
                end
                default: state <= ST_CLOSED;
            endcase
        end
    end
endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for the controller's memory-side timing, bound to the top.
// Counts strobe low/high widths itself and checks them at the strobe edges.
module fpm_dram_ctrl_chk #(
    parameter int T_RAS  = 5,
    parameter int T_RP   = 3,
    parameter int T_RCD  = 2,
    parameter int T_CP   = 1,
    parameter int T_RASP = 10000
) (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic oe_n,
    input logic dq_oe,
    input logic rd_valid,
    input logic ref_grant
);
    localparam int CW = $clog2(T_RASP + T_RP + T_CP + 4) + 1;
    localparam logic [CW-1:0] CMAX = '1;

    logic [CW-1:0] lo_cnt, hi_cnt, chi_cnt;

    // Width counters for row strobe low/high and column strobe high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt  <= '0;
            hi_cnt  <= CW'(T_RP);
            chi_cnt <= CW'(T_CP);
        end else begin
            lo_cnt  <= ras_n ? '0 : ((lo_cnt == CMAX) ? lo_cnt : lo_cnt + 1'b1);
            hi_cnt  <= !ras_n ? '0 : ((hi_cnt == CMAX) ? hi_cnt : hi_cnt + 1'b1);
            chi_cnt <= !cas_n ? '0 : ((chi_cnt == CMAX) ? chi_cnt : chi_cnt + 1'b1);
        end
    end

    a_r2_ras_min_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> lo_cnt >= CW'(T_RAS));
    a_r3_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> hi_cnt >= CW'(T_RP));
    a_r4_rcd: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> lo_cnt >= CW'(T_RCD));
    a_r4_cas_in_row: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);
    a_r5_cas_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> chi_cnt >= CW'(T_CP));
    a_r6_early_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && !we_n) |-> (oe_n && dq_oe));
    a_r7_read_dir: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && we_n) |-> (!oe_n && !dq_oe));
    a_r7_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $rose(cas_n));
    a_r9_rasp: assert property (@(posedge clk) disable iff (!rst_n)
        lo_cnt <= CW'(T_RASP));
    a_r10_grant_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_grant && ras_n) |=> ras_n);
endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(
    .T_RAS(T_RAS), .T_RP(T_RP), .T_RCD(T_RCD), .T_CP(T_CP), .T_RASP(T_RASP)
) chk_i (
    .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
    .we_n(dram_we_n), .oe_n(dram_oe_n), .dq_oe(dq_oe),
    .rd_valid(rd_valid), .ref_grant(ref_grant)
);

// File: tb/fpm_dram_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench: memory model on the device pins, host driver, timing monitors,
// shadow memory for expected read data.
module fpm_dram_ctrl_tb_top;
    localparam int T_RAS = 5, T_RP = 3, T_RCD = 2, T_CP = 1, T_PC = 2;
    localparam int T_CAC = 2, T_RASP = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, ref_grant = 1'b0;
    logic [21:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic        req_ready, rd_valid;
    logic [3:0]  rd_data;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
    logic [10:0] dram_addr;
    wire  [3:0]  dram_dq;

    int n_chk = 0, n_bad = 0, ras_falls = 0;
    bit finished = 0, grant_win = 0;

    always #2 clk = ~clk;

    fpm_dram_ctrl #(.T_RASP(T_RASP)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .ref_grant(ref_grant),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq(dram_dq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [3:0]  mem [bit [21:0]];
    logic [3:0]  shadow [bit [21:0]];
    logic [10:0] m_row = '0;
    logic [3:0]  m_rd = '0;
    int          cas_lo_cyc = 0;
    logic [10:0] last_row = '0, last_col = '0;
    logic [3:0]  last_wd = '0;
    logic [3:0]  exp_q [$];

    function automatic logic [3:0] exp_read(input logic [21:0] a);
        return shadow.exists(a) ? shadow[a] : 4'h0;
    endfunction

    wire       model_drv = !dram_ras_n && !dram_cas_n && !dram_oe_n && dram_we_n;
    wire [3:0] model_val = (cas_lo_cyc >= T_CAC - 1) ? m_rd : ~m_rd;
    assign dram_dq = model_drv ? model_val : 4'bz;

    always @(posedge clk) cas_lo_cyc <= dram_cas_n ? 0 : cas_lo_cyc + 1;

    always @(negedge dram_ras_n) m_row = dram_addr;

    // Column strobe fall: latch column, store early-write data, check R1/R6.
    always @(negedge dram_cas_n) begin
        if (rst_n) begin
            check(m_row == last_row, "R1 row pins", int'(m_row), int'(last_row));
            check(dram_addr == last_col, "R1 col pins", int'(dram_addr), int'(last_col));
            if (!dram_we_n) begin
                check(dram_dq == last_wd, "R6 write data", int'(dram_dq), int'(last_wd));
                check(dram_oe_n == 1'b1, "R6 oe high", int'(dram_oe_n), 1);
                mem[{m_row, dram_addr}] = dram_dq;
            end else begin
                check(dram_oe_n == 1'b0, "R7 oe low", int'(dram_oe_n), 0);
            end
            m_rd = mem.exists({m_row, dram_addr}) ? mem[{m_row, dram_addr}] : 4'h0;
        end
    end

    // ---------------- timing and response monitors ----------------
    int  lo_run = 0, hi_run = 1000, chi_run = 1000, since_cas = 1000;
    bit  p_ras = 1, p_cas = 1, p_rdv = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_ras && !dram_ras_n) begin
                ras_falls++;
                check(hi_run >= T_RP, "R3 precharge", hi_run, T_RP);
                check(!grant_win, "R10 no open under grant", 1, 0);
            end
            if (!p_ras && dram_ras_n) begin
                check(lo_run >= T_RAS, "R2 ras low", lo_run, T_RAS);
                check(lo_run <= T_RASP, "R9 ras max", lo_run, T_RASP);
            end
            lo_run = dram_ras_n ? 0 : lo_run + 1;
            hi_run = dram_ras_n ? hi_run + 1 : 0;
            if (p_cas && !dram_cas_n) begin
                check(!dram_ras_n, "R4 cas in row", int'(dram_ras_n), 0);
                check(lo_run >= T_RCD + 1, "R4 rcd", lo_run - 1, T_RCD);
                check(chi_run >= T_CP, "R5 cas high", chi_run, T_CP);
                check(since_cas >= T_PC, "R5 page spacing", since_cas, T_PC);
                since_cas = 0;
            end
            since_cas++;
            chi_run = dram_cas_n ? chi_run + 1 : 0;
            if (rd_valid) begin
                check(!p_rdv, "R7 single pulse", 1, 0);
                if (exp_q.size() == 0) check(0, "R12 extra read", 1, 0);
                else begin
                    logic [3:0] e;
                    e = exp_q.pop_front();
                    check(rd_data == e, "R7 read data", int'(rd_data), int'(e));
                end
            end
            p_ras = dram_ras_n; p_cas = dram_cas_n; p_rdv = rd_valid;
        end
    end

    // ---------------- host driver ----------------
    task automatic host_op(input bit wr, input logic [21:0] a, input logic [3:0] d);
        req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        last_row = a[21:11]; last_col = a[10:0]; last_wd = d;
        if (wr) shadow[a] = d;
        else exp_q.push_back(exp_read(a));
        req_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (8) @(negedge clk);
        check(exp_q.size() == 0, "R12 all reads answered", exp_q.size(), 0);
    endtask

    task automatic close_by_grant(input int hold);
        @(negedge clk);
        ref_grant = 1'b1;
        repeat (12) @(negedge clk);
        check(dram_ras_n == 1'b1, "R10 row closed", int'(dram_ras_n), 1);
        check(req_ready == 1'b0, "R10 not ready", int'(req_ready), 0);
        grant_win = 1;
        repeat (hold) @(negedge clk);
        check(dram_ras_n == 1'b1, "R10 stays idle", int'(dram_ras_n), 1);
        grant_win = 0;
        ref_grant = 1'b0;
        @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        int f0;
        void'($urandom(32'h1d5a7));
        repeat (3) @(negedge clk);
        check(dram_ras_n && dram_cas_n, "R11 strobes in reset", int'({dram_ras_n, dram_cas_n}), 3);
        check(dram_we_n && dram_oe_n, "R11 we/oe in reset", int'({dram_we_n, dram_oe_n}), 3);
        check(!rd_valid, "R11 no read in reset", int'(rd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R11 ready after reset", int'(req_ready), 1);
        check(dram_ras_n == 1'b1, "R11 ras idle", int'(dram_ras_n), 1);

        // R5: page burst in one row, one row strobe fall.
        f0 = ras_falls;
        for (int i = 0; i < 4; i++) host_op(1, {11'd5, 11'(i * 3)}, 4'(i + 9));
        for (int i = 0; i < 4; i++) host_op(0, {11'd5, 11'(i * 3)}, 4'h0);
        drain();
        check(ras_falls - f0 == 1, "R5 page hits", ras_falls - f0, 1);

        // R8/R1: same columns in another row, then back.
        host_op(1, {11'd6, 11'd0}, 4'h3);
        host_op(1, {11'd6, 11'd3}, 4'h4);
        host_op(0, {11'd5, 11'd0}, 4'h0);
        host_op(0, {11'd6, 11'd3}, 4'h0);
        host_op(0, {11'h7ff, 11'h7ff}, 4'h0);
        drain();
        check(ras_falls - f0 == 5, "R8 row misses", ras_falls - f0, 5);

        // R10: grant closes the open row and holds it closed.
        host_op(1, {11'd9, 11'd1}, 4'h7);
        close_by_grant(20);

        // R9: long same-row stream must reopen the row.
        f0 = ras_falls;
        for (int i = 0; i < 40; i++) host_op(i % 3 != 0, {11'd12, 11'(i)}, 4'(i));
        drain();
        check(ras_falls - f0 >= 2, "R9 forced reopen", ras_falls - f0, 2);

        // Constrained random traffic over a few rows.
        for (int i = 0; i < 400; i++) begin
            logic [10:0] r, c;
            r = ($urandom_range(0, 7) == 0) ? 11'h7ff : 11'($urandom_range(0, 3));
            c = 11'($urandom_range(0, 15));
            host_op($urandom_range(0, 1) == 1, {r, c}, 4'($urandom_range(0, 15)));
            repeat ($urandom_range(0, 3)) @(negedge clk);
            if (i == 200) close_by_grant(5);
        end
        drain();

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule